// File: doc/BRIEF.md
# PCI Bus Arbiter with Parking

This block is the central arbiter of a conventional PCI bus. It serves several external agents, each with an active-low request and grant pair, and one internal host agent. The host agent also uses a request/grant pair, and it takes the highest index. The arbiter watches FRAME, IRDY and LOCK. It decides which agent owns the bus. When nobody is asking, it also decides which agent gets a parking grant, so that the shared address/data, command and parity lines stay driven.

Three fields of a 16-bit configuration word shape its behaviour. A two-bit parking selector sits at bits 14:13. Bit 12 is an active-low enable for locking out a broken master. Bit 11 turns on bus-lock holding. Requests compete in round-robin order. An agent that holds a grant on an idle bus for 16 clocks without starting a transaction loses the grant. Its requests are then ignored until it releases REQ.

Top module: `pci_park_arbiter`

## Requirements
- R1: After reset every GNT line is high (deasserted) and every lock-out flag is 0. At no time is more than one GNT line low.
- R2: When the grant moves from one agent to a different agent, all GNT lines are high for exactly one clock in between.
- R3: Unmasked requests are granted in round-robin order. The search starts at the index after the agent that most recently started a transaction, wraps past the host index (the highest) back to 0, and skips agents that are not requesting.
- R4: With parking field bits 14:13 = 00 or 11 and no request pending, the bus is parked on the agent that most recently started a transaction.
- R5: With parking field 10, an idle bus (FRAME and IRDY both high) and no request pending, the bus is parked on the host agent.
- R6: With parking field 01, an idle bus and no request pending, the bus is parked on external agent 0.
- R7: On the clock in which a transaction ends (FRAME high, IRDY low), parking falls back to the last master whatever the parking field holds.
- R8: With bit 12 = 0, an external agent that holds a grant with REQ low on an idle bus for 16 consecutive clocks gets its lock-out flag set after the 16th clock, and its grant is then removed.
- R9: The requests of a locked-out agent are ignored. One clock with its REQ high clears the flag, and the agent may then win the bus again.
- R10: With bit 12 = 1, no agent is locked out. A granted requester keeps its grant beyond 16 clocks until it deasserts REQ.
- R11: With bit 11 = 1, while LOCK is low the grant stays with the agent that last started a transaction, even on an idle bus and with other requests pending.
- R12: While FRAME is low, the grant does not change.
- R13: If the selected parking target is locked out, the bus is parked on the host agent instead. The host agent is never locked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_n_i | input | NUM_EXT+1 | Active-low requests; the top bit is the host agent |
| frame_n_i | input | 1 | Bus FRAME, active low |
| irdy_n_i | input | 1 | Bus IRDY, active low |
| lock_n_i | input | 1 | Bus LOCK, active low |
| arb_cfg_i | input | 16 | Configuration word: [14:13] parking, [12] lock-out disable, [11] lock hold |
| gnt_n_o | output | NUM_EXT+1 | Active-low grants; the top bit is the host agent |
| lockout_o | output | NUM_EXT+1 | Per-agent lock-out flag, 1 = requests ignored |

## Verification
The arbitration path is driven with three kinds of request pattern. A lone requester shows the one-clock handover gap and the parking choice that follows. Three simultaneous requesters, served across back-to-back transactions, tell true round-robin apart from fixed priority and show that the grant is frozen while FRAME is low. A requester that never starts a transaction is run with lock-out enabled and disabled. This separates the 16th-clock strip, the shunning that follows and the release on REQ high. A held LOCK shows the lock-owner hold against a pending competitor.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

  localparam int unsigned CFG_W        = 16;
  localparam int unsigned CFG_PARK_LSB = 13;
  localparam int unsigned CFG_WD_DIS   = 12;
  localparam int unsigned CFG_LOCK_EN  = 11;

  typedef enum logic [1:0] {
    PARK_LAST     = 2'b00,
    PARK_AGENT0   = 2'b01,
    PARK_HOST     = 2'b10,
    PARK_LAST_ALT = 2'b11
  } park_mode_e;

  typedef struct packed {
    park_mode_e park;
    logic       wd_en;
    logic       lock_hold;
  } arb_cfg_t;

  function automatic arb_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
    arb_cfg_t c;
    c.park      = park_mode_e'(raw[CFG_PARK_LSB +: 2]);
    c.wd_en     = ~raw[CFG_WD_DIS];
    c.lock_hold = raw[CFG_LOCK_EN];
    return c;
  endfunction

endpackage

// File: rtl/pci_arb_rr_pick.sv
module pci_arb_rr_pick #(
  parameter int unsigned NAG = 5,
  localparam int unsigned IW = $clog2(NAG)
) (
  input  logic [NAG-1:0] elig_i,
  input  logic [IW-1:0]  base_i,
  output logic           found_o,
  output logic [IW-1:0]  pick_o
);

  always_comb begin
    int c;
    found_o = 1'b0;
    pick_o  = base_i;
    for (int k = 1; k <= int'(NAG); k++) begin
      c = (int'(base_i) + k) % int'(NAG);
      if (!found_o && elig_i[c]) begin
        found_o = 1'b1;
        pick_o  = IW'(c);
      end
    end
  end

endmodule

// File: rtl/pci_arb_watchdog.sv
module pci_arb_watchdog #(
  parameter int unsigned NAG   = 5,
  parameter int unsigned HOST  = 4,
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wd_en_i,
  input  logic           bus_idle_i,
  input  logic [NAG-1:0] gnt_oh_i,
  input  logic [NAG-1:0] req_n_i,
  output logic [NAG-1:0] shun_o
);

  logic [CW-1:0]  cnt_q;
  logic [NAG-1:0] watch_mask;
  logic           armed;
  logic           trip;

  always_comb begin
    watch_mask       = '1;
    watch_mask[HOST] = 1'b0;
  end

  // a granted, requesting, non-host agent sitting on an idle bus
  assign armed = wd_en_i && bus_idle_i &&
                 |(gnt_oh_i & ~req_n_i & ~shun_o & watch_mask);
  assign trip  = armed && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!armed)  cnt_q <= '0;
    else if (trip)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < int'(NAG); i++) begin : g_shun
    if (i == int'(HOST)) begin : g_host
      assign shun_o[i] = 1'b0;
    end else begin : g_ext
      logic shun_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)                 shun_q <= 1'b0;
        else if (req_n_i[i])         shun_q <= 1'b0;
        else if (trip && gnt_oh_i[i]) shun_q <= 1'b1;
      end
      assign shun_o[i] = shun_q;
    end
  end

endmodule

// File: rtl/pci_park_arbiter.sv
module pci_park_arbiter
  import pci_arb_pkg::*;
#(
  parameter int unsigned NUM_EXT  = 4,
  parameter int unsigned WD_LIMIT = 16,
  localparam int unsigned NAG     = NUM_EXT + 1,
  localparam int unsigned IW      = $clog2(NAG),
  localparam int unsigned HOST    = NUM_EXT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NAG-1:0]   req_n_i,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic             lock_n_i,
  input  logic [CFG_W-1:0] arb_cfg_i,
  output logic [NAG-1:0]   gnt_n_o,
  output logic [NAG-1:0]   lockout_o
);

  arb_cfg_t       cfg;
  logic           gnt_vld_q, gnt_vld_d;
  logic [IW-1:0]  gnt_idx_q, gnt_idx_d;
  logic [IW-1:0]  last_q;
  logic           frame_q;
  logic [NAG-1:0] gnt_oh;
  logic [NAG-1:0] shun;
  logic [NAG-1:0] elig;
  logic           bus_idle, arb_ok, txn_start, lock_keep;
  logic           rr_found;
  logic [IW-1:0]  rr_pick;
  logic [IW-1:0]  park_sel, park_tgt, target;
  logic           unused_cfg;

  assign cfg        = decode_cfg(arb_cfg_i);
  assign unused_cfg = ^{arb_cfg_i[CFG_W-1], arb_cfg_i[CFG_LOCK_EN-1:0]};

  assign bus_idle  = frame_n_i && irdy_n_i;
  assign arb_ok    = frame_n_i;              // idle, or final data phase
  assign txn_start = !frame_n_i && frame_q;
  assign lock_keep = cfg.lock_hold && !lock_n_i;
  assign gnt_oh    = gnt_vld_q ? (NAG'(1) << gnt_idx_q) : '0;
  assign elig      = ~req_n_i & ~shun;

  pci_arb_rr_pick #(.NAG(NAG)) u_pick (
    .elig_i  (elig),
    .base_i  (last_q),
    .found_o (rr_found),
    .pick_o  (rr_pick)
  );

  pci_arb_watchdog #(.NAG(NAG), .HOST(HOST), .LIMIT(WD_LIMIT)) u_wd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wd_en_i    (cfg.wd_en),
    .bus_idle_i (bus_idle),
    .gnt_oh_i   (gnt_oh),
    .req_n_i    (req_n_i),
    .shun_o     (shun)
  );

  // parking choice
  always_comb begin
    unique case (cfg.park)
      PARK_HOST:   park_sel = bus_idle ? IW'(HOST) : last_q;
      PARK_AGENT0: park_sel = bus_idle ? '0 : last_q;
      default:     park_sel = last_q;
    endcase
    park_tgt = |(shun & (NAG'(1) << park_sel)) ? IW'(HOST) : park_sel;
  end

  always_comb begin
    if (lock_keep)     target = last_q;
    else if (rr_found) target = rr_pick;
    else               target = park_tgt;
  end

  // grant update with a one-clock gap on every handover
  always_comb begin
    gnt_vld_d = gnt_vld_q;
    gnt_idx_d = gnt_idx_q;
    if (arb_ok) begin
      if (gnt_vld_q && (gnt_idx_q != target)) begin
        gnt_vld_d = 1'b0;
      end else begin
        gnt_vld_d = 1'b1;
        gnt_idx_d = target;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gnt_vld_q <= 1'b0;
      gnt_idx_q <= IW'(HOST);
      last_q    <= IW'(HOST);
      frame_q   <= 1'b1;
    end else begin
      gnt_vld_q <= gnt_vld_d;
      gnt_idx_q <= gnt_idx_d;
      frame_q   <= frame_n_i;
      if (txn_start && gnt_vld_q) last_q <= gnt_idx_q;
    end
  end

  assign gnt_n_o   = ~gnt_oh;
  assign lockout_o = shun;

endmodule

// File: rtl/pci_park_arbiter_chk.sv
module pci_park_arbiter_chk
  import pci_arb_pkg::*;
#(
  parameter int unsigned NUM_EXT = 4,
  localparam int unsigned NAG    = NUM_EXT + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NAG-1:0]   req_n_i,
  input logic             frame_n_i,
  input logic             irdy_n_i,
  input logic             lock_n_i,
  input logic [CFG_W-1:0] arb_cfg_i,
  input logic [NAG-1:0]   gnt_n_o,
  input logic [NAG-1:0]   lockout_o
);

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~gnt_n_o)); // R1

  AST_HANDOVER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_n_o != '1) && ($past(gnt_n_o) != '1)) |-> (gnt_n_o == $past(gnt_n_o))); // R2

  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_n_i |=> $stable(gnt_n_o)); // R12

  for (genvar i = 0; i < int'(NAG); i++) begin : g_ag
    AST_SHUN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lockout_o[i] && req_n_i[i]) |=> !lockout_o[i]); // R9

    AST_WD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lockout_o[i]) |-> !$past(arb_cfg_i[CFG_WD_DIS])); // R10
  end

endmodule

bind pci_park_arbiter pci_park_arbiter_chk #(.NUM_EXT(NUM_EXT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_n_i   (req_n_i),
  .frame_n_i (frame_n_i),
  .irdy_n_i  (irdy_n_i),
  .lock_n_i  (lock_n_i),
  .arb_cfg_i (arb_cfg_i),
  .gnt_n_o   (gnt_n_o),
  .lockout_o (lockout_o)
);

// File: tb/pci_park_arbiter_bench.sv
module pci_park_arbiter_bench;

  localparam int NEXT = 4;
  localparam int NAG  = NEXT + 1;
  localparam int HOST = NEXT;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NAG-1:0] req_n = '1;
  logic           frame_n = 1'b1;
  logic           irdy_n = 1'b1;
  logic           lock_n = 1'b1;
  logic [15:0]    cfg = '0;
  logic [NAG-1:0] gnt_n;
  logic [NAG-1:0] lockout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pci_park_arbiter #(.NUM_EXT(NEXT)) u_pci_park_arbiter (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .req_n_i   (req_n),
    .frame_n_i (frame_n),
    .irdy_n_i  (irdy_n),
    .lock_n_i  (lock_n),
    .arb_cfg_i (cfg),
    .gnt_n_o   (gnt_n),
    .lockout_o (lockout)
  );

  // index of the granted agent, -1 none, -2 several
  function automatic int who();
    int w = -1;
    for (int i = 0; i < NAG; i++) begin
      if (!gnt_n[i]) w = (w == -1) ? i : -2;
    end
    return w;
  endfunction

  function automatic logic [15:0] mk_cfg(input logic [1:0] park, input logic wd_dis,
                                          input logic lock_en);
    logic [15:0] c = '0;
    c[14:13] = park;
    c[12]    = wd_dis;
    c[11]    = lock_en;
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_gnt(input int exp, input string req);
    chk(who() == exp, req, who(), exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // agent ag holds the grant; runs a two-phase transaction and drops REQ
  task automatic run_txn(input int ag);
    frame_n = 1'b0; irdy_n = 1'b0; req_n[ag] = 1'b1;
    cyc(1); chk_gnt(ag, "R12 grant frozen in transaction");
    cyc(1); chk_gnt(ag, "R12 grant frozen in transaction");
    frame_n = 1'b1;
    cyc(1);
    irdy_n = 1'b1;
  endtask

  task automatic t_reset();
    cyc(3);
    chk(gnt_n == '1, "R1 reset grants high", int'(gnt_n), 31);
    chk(lockout == '0, "R1 reset lock-out clear", int'(lockout), 0);
    rst_n = 1'b1;
    cyc(2);
    chk_gnt(HOST, "R4 initial park on last master");
  endtask

  task automatic t_park_last();
    req_n[2] = 1'b0;
    cyc(1); chk_gnt(-1, "R2 handover gap");
    cyc(1); chk_gnt(2, "R3 lone requester granted");
    run_txn(2);
    cyc(3); chk_gnt(2, "R4 mode 00 parks on last master");
    cfg = mk_cfg(2'b11, 1'b0, 1'b0);
    cyc(3); chk_gnt(2, "R4 mode 11 parks on last master");
  endtask

  task automatic t_idle_fallback();
    cfg = mk_cfg(2'b10, 1'b0, 1'b0);
    cyc(3); chk_gnt(HOST, "R5 mode 10 parks on host");
    req_n[1] = 1'b0;
    cyc(3); chk_gnt(1, "R3 requester 1 granted");
    run_txn(1);
    chk_gnt(1, "R7 end cycle parks on last master");
    cyc(1); chk_gnt(-1, "R2 gap before parking move");
    cyc(1); chk_gnt(HOST, "R5 idle parks on host");
  endtask

  task automatic t_park_ag0();
    cfg = mk_cfg(2'b01, 1'b0, 1'b0);
    cyc(3); chk_gnt(0, "R6 mode 01 parks on agent 0");
  endtask

  task automatic t_round_robin();
    cfg = mk_cfg(2'b00, 1'b0, 1'b0);
    req_n[0] = 1'b0; req_n[2] = 1'b0; req_n[3] = 1'b0;
    cyc(3); chk_gnt(2, "R3 first after last owner 1");
    run_txn(2);
    cyc(2); chk_gnt(3, "R3 next after owner 2");
    run_txn(3);
    cyc(2); chk_gnt(0, "R3 wrap past host to agent 0");
    req_n[0] = 1'b1;
    cyc(3);
  endtask

  task automatic t_watchdog();
    cfg = mk_cfg(2'b01, 1'b0, 1'b0);
    cyc(3); chk_gnt(0, "R6 parked on agent 0");
    req_n[0] = 1'b0;
    cyc(15);
    chk(lockout[0] == 1'b0, "R8 no lock-out before 16 clocks", int'(lockout[0]), 0);
    chk_gnt(0, "R8 grant kept within 16 clocks");
    cyc(1);
    chk(lockout[0] == 1'b1, "R8 lock-out after 16 clocks", int'(lockout[0]), 1);
    cyc(2); chk_gnt(HOST, "R13 locked-out park target replaced by host");
    cfg = mk_cfg(2'b10, 1'b0, 1'b0);
    cyc(5);
    chk_gnt(HOST, "R9 request of locked-out agent ignored");
    chk(lockout[0] == 1'b1, "R9 lock-out held while REQ low", int'(lockout[0]), 1);
    req_n[0] = 1'b1;
    cyc(1);
    chk(lockout[0] == 1'b0, "R9 lock-out cleared by REQ high", int'(lockout[0]), 0);
    req_n[0] = 1'b0;
    cyc(3); chk_gnt(0, "R9 agent competes again");
    req_n[0] = 1'b1;
    cyc(3); chk_gnt(HOST, "R5 back to host parking");
  endtask

  task automatic t_wd_disabled();
    cfg = mk_cfg(2'b10, 1'b1, 1'b0);
    req_n[3] = 1'b0;
    cyc(25);
    chk_gnt(3, "R10 grant kept with lock-out disabled");
    chk(lockout == '0, "R10 no lock-out when disabled", int'(lockout), 0);
    req_n[3] = 1'b1;
    cyc(3); chk_gnt(HOST, "R10 grant released on REQ high");
  endtask

  task automatic t_lock_hold();
    cfg = mk_cfg(2'b00, 1'b0, 1'b1);
    req_n[1] = 1'b0;
    cyc(3); chk_gnt(1, "R3 locking master granted");
    lock_n = 1'b0; req_n[2] = 1'b0;
    run_txn(1);
    cyc(5); chk_gnt(1, "R11 grant held for LOCK owner");
    lock_n = 1'b1;
    cyc(3); chk_gnt(2, "R11 grant moves after LOCK release");
    req_n[2] = 1'b1;
    cyc(3);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    t_reset();
    t_park_last();
    t_idle_fallback();
    t_park_ag0();
    t_round_robin();
    t_watchdog();
    t_wd_disabled();
    t_lock_hold();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

endmodule